// File: doc/BRIEF.md
# Boundary-Scan Pad Cell

This block is one boundary-scan cell placed between a core-side signal group (output, output enable, input) and a pad-side signal group (output, output enable, input). It holds a one-bit scan stage and a one-bit held value. The cell joins a serial scan path through `scan_in` and `scan_out`. A connection-mode input chooses whether the pad and the core are wired straight to each other or see the held value. A sampling-mode input chooses among idle, capture, update and shift.

The scan stage changes on the rising edge of `tck`. The held value changes on the falling edge. An update requested in a cycle therefore reaches the pad or core half a period after the capture or shift edge, which is the usual scan timing. The parameter `CAPTURE_CORE` chooses what a capture records. A value of 0 records the pad input, for a cell used as an input. A value of 1 records the core output, for a cell used as an output. The controller that drives the two mode inputs, and the chaining of many cells, lie outside the block. The data here is a single scan bit with no flow control, so every pin is a plain level.

Top module: `bsc_iocell`

## Requirements
- R1: While `rst_n` is low, the scan stage and the held value are both 0. Just after release, `scan_out` is 0, and in connection mode 3 both `pad_out` and `core_in` are 0.
- R2: Connection mode 0 (straight): `pad_out` = `core_out`, `pad_en` = `core_en`, `core_in` = `pad_in`.
- R3: Connection mode 1 (held to pad): `pad_out` = held value, `pad_en` = 1, `core_in` = `pad_in`.
- R4: Connection mode 2 (held to core): `core_in` = held value, `pad_out` = `core_out`, `pad_en` = `core_en`.
- R5: Connection mode 3 (held to both): `pad_out` = held value, `core_in` = held value, `pad_en` = 1.
- R6: Connection mode 4 (pad released): `pad_en` = 0, `pad_out` = `core_out`, `core_in` = `pad_in`. Codes 5 to 7 behave the same as code 4.
- R7: Sampling mode 1 (capture): at the rising edge of `tck`, the scan stage loads `pad_in` when `CAPTURE_CORE` = 0 and `core_out` when `CAPTURE_CORE` = 1.
- R8: Sampling mode 3 (shift): `scan_out` shows the scan stage, and at the rising edge of `tck` the stage loads `scan_in`.
- R9: Sampling mode 2 (update): at the falling edge of `tck`, the held value loads the scan stage. Before that falling edge, the outputs still show the old held value.
- R10: Sampling mode 0 (idle) keeps both the stage and the held value. Capture and shift leave the held value unchanged, and update leaves the stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; stage on rising edge, held value on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_mode | input | 3 | Connection mode, codes per R2 to R6 |
| samp_mode | input | 2 | Sampling mode: 0 idle, 1 capture, 2 update, 3 shift |
| core_out | input | 1 | Value the core wants on the pad |
| core_en | input | 1 | Core's output enable for the pad |
| core_in | output | 1 | Value presented to the core |
| pad_in | input | 1 | Value read from the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_en | output | 1 | Pad driver enable |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output (scan stage) |

## Verification
The bench builds two copies of the cell side by side on the same stimulus. One uses `CAPTURE_CORE` = 0 and the other uses `CAPTURE_CORE` = 1. A single capture with `core_out` and `pad_in` set to different values then shows both capture sources at once. Outputs are checked between the rising and falling edges, so a value still waiting for its falling-edge update is distinguished from one already applied.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    CONN_THRU    = 3'd0,
    CONN_TO_PAD  = 3'd1,
    CONN_TO_CORE = 3'd2,
    CONN_BOTH    = 3'd3,
    CONN_HIZ     = 3'd4
  } conn_e;

  typedef enum logic [1:0] {
    SAMP_IDLE    = 2'd0,
    SAMP_CAPTURE = 2'd1,
    SAMP_UPDATE  = 2'd2,
    SAMP_SHIFT   = 2'd3
  } samp_e;
endpackage

// File: rtl/bsc_scan_stage.sv
module bsc_scan_stage #(
  parameter bit CAPTURE_CORE = 1'b0
) (
  input  logic           tck,
  input  logic           rst_n,
  input  bsc_pkg::samp_e samp,
  input  logic           core_out,
  input  logic           pad_in,
  input  logic           scan_in,
  output logic           stage_q
);
  logic cap_bit;

  // The capture source is fixed when the cell is built.
  generate
    if (CAPTURE_CORE) begin : g_cap_core
      assign cap_bit = core_out;
    end else begin : g_cap_pad
      assign cap_bit = pad_in;
    end
  endgenerate

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
    end else begin
      unique case (samp)
        bsc_pkg::SAMP_CAPTURE: stage_q <= cap_bit;
        bsc_pkg::SAMP_SHIFT:   stage_q <= scan_in;
        default:               stage_q <= stage_q;
      endcase
    end
  end
endmodule

// File: rtl/bsc_hold_latch.sv
module bsc_hold_latch (
  input  logic           tck,
  input  logic           rst_n,
  input  bsc_pkg::samp_e samp,
  input  logic           stage_q,
  output logic           hold_q
);
  // The held value moves on the falling edge, half a period after the stage.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (samp == bsc_pkg::SAMP_UPDATE) begin
      hold_q <= stage_q;
    end
  end
endmodule

// File: rtl/bsc_route.sv
module bsc_route (
  input  bsc_pkg::conn_e conn,
  input  logic           hold_q,
  input  logic           core_out,
  input  logic           core_en,
  input  logic           pad_in,
  output logic           core_in,
  output logic           pad_out,
  output logic           pad_en
);
  always_comb begin
    core_in = pad_in;
    pad_out = core_out;
    pad_en  = core_en;
    unique case (conn)
      bsc_pkg::CONN_THRU: begin
      end
      bsc_pkg::CONN_TO_PAD: begin
        pad_out = hold_q;
        pad_en  = 1'b1;
      end
      bsc_pkg::CONN_TO_CORE: begin
        core_in = hold_q;
      end
      bsc_pkg::CONN_BOTH: begin
        pad_out = hold_q;
        pad_en  = 1'b1;
        core_in = hold_q;
      end
      default: begin
        pad_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bsc_iocell.sv
module bsc_iocell #(
  parameter bit CAPTURE_CORE = 1'b0
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic [2:0] conn_mode,
  input  logic [1:0] samp_mode,
  input  logic       core_out,
  input  logic       core_en,
  output logic       core_in,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_en,
  input  logic       scan_in,
  output logic       scan_out
);
  bsc_pkg::conn_e conn;
  bsc_pkg::samp_e samp;
  logic           stage_q;
  logic           hold_q;

  assign conn = bsc_pkg::conn_e'(conn_mode);
  assign samp = bsc_pkg::samp_e'(samp_mode);

  bsc_scan_stage #(.CAPTURE_CORE(CAPTURE_CORE)) u_stage (
    .tck      (tck),
    .rst_n    (rst_n),
    .samp     (samp),
    .core_out (core_out),
    .pad_in   (pad_in),
    .scan_in  (scan_in),
    .stage_q  (stage_q)
  );

  bsc_hold_latch u_hold (
    .tck     (tck),
    .rst_n   (rst_n),
    .samp    (samp),
    .stage_q (stage_q),
    .hold_q  (hold_q)
  );

  bsc_route u_route (
    .conn     (conn),
    .hold_q   (hold_q),
    .core_out (core_out),
    .core_en  (core_en),
    .pad_in   (pad_in),
    .core_in  (core_in),
    .pad_out  (pad_out),
    .pad_en   (pad_en)
  );

  assign scan_out = stage_q;
endmodule

// File: rtl/bsc_iocell_chk.sv
module bsc_iocell_chk #(
  parameter bit CAPTURE_CORE = 1'b0
) (
  input logic       tck,
  input logic       rst_n,
  input logic [2:0] conn_mode,
  input logic [1:0] samp_mode,
  input logic       core_out,
  input logic       core_en,
  input logic       core_in,
  input logic       pad_in,
  input logic       pad_out,
  input logic       pad_en,
  input logic       scan_in,
  input logic       scan_out
);
  AST_THRU_WIRED: assert property (@(posedge tck) disable iff (!rst_n)
    (conn_mode == 3'd0) |-> (pad_out == core_out && pad_en == core_en && core_in == pad_in)); // R2

  AST_HIZ_OFF: assert property (@(posedge tck) disable iff (!rst_n)
    (conn_mode >= 3'd4) |-> (!pad_en && core_in == pad_in)); // R6

  AST_CAPTURE_SRC: assert property (@(posedge tck) disable iff (!rst_n)
    (samp_mode == 2'd1) |=> (scan_out == $past(CAPTURE_CORE ? core_out : pad_in))); // R7

  AST_SHIFT_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
    (samp_mode == 2'd3) |=> (scan_out == $past(scan_in))); // R8

  AST_IDLE_KEEP: assert property (@(posedge tck) disable iff (!rst_n)
    (samp_mode == 2'd0 || samp_mode == 2'd2) |=> $stable(scan_out)); // R10

  AST_BOTH_DRIVE: assert property (@(posedge tck) disable iff (!rst_n)
    (conn_mode == 3'd3) |-> (pad_en && pad_out == core_in)); // R5
endmodule

bind bsc_iocell bsc_iocell_chk #(.CAPTURE_CORE(CAPTURE_CORE)) u_chk (
  .tck       (tck),
  .rst_n     (rst_n),
  .conn_mode (conn_mode),
  .samp_mode (samp_mode),
  .core_out  (core_out),
  .core_en   (core_en),
  .core_in   (core_in),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_en    (pad_en),
  .scan_in   (scan_in),
  .scan_out  (scan_out)
);

// File: tb/bsc_iocell_bench.sv
module bsc_iocell_bench;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] conn_mode = 3'd0;
  logic [1:0] samp_mode = 2'd0;
  logic       core_out = 1'b0;
  logic       core_en = 1'b0;
  logic       pad_in = 1'b0;
  logic       scan_in = 1'b0;
  logic       core_in_a, pad_out_a, pad_en_a, scan_out_a;
  logic       core_in_b, pad_out_b, pad_en_b, scan_out_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  string      q_tag[$];
  logic [7:0] q_exp[$];

  // bench model state: a = pad capture, b = core capture
  logic sr_a = 1'b0, sr_b = 1'b0, hold = 1'b0;

  always #4 tck = ~tck;

  bsc_iocell #(.CAPTURE_CORE(1'b0)) u_bsc_iocell (
    .tck(tck), .rst_n(rst_n), .conn_mode(conn_mode), .samp_mode(samp_mode),
    .core_out(core_out), .core_en(core_en), .core_in(core_in_a),
    .pad_in(pad_in), .pad_out(pad_out_a), .pad_en(pad_en_a),
    .scan_in(scan_in), .scan_out(scan_out_a)
  );

  bsc_iocell #(.CAPTURE_CORE(1'b1)) u_bsc_iocell_core (
    .tck(tck), .rst_n(rst_n), .conn_mode(conn_mode), .samp_mode(samp_mode),
    .core_out(core_out), .core_en(core_en), .core_in(core_in_b),
    .pad_in(pad_in), .pad_out(pad_out_b), .pad_en(pad_en_b),
    .scan_in(scan_in), .scan_out(scan_out_b)
  );

  // expected {scan_out, pad_out, pad_en, core_in}
  function automatic logic [3:0] model(input logic [2:0] cm, input logic sr, input logic h,
                                       input logic co, input logic ce, input logic pi);
    logic po, pe, ci;
    po = co; pe = ce; ci = pi;
    case (cm)
      3'd0: ;
      3'd1: begin po = h; pe = 1'b1; end
      3'd2: ci = h;
      3'd3: begin po = h; pe = 1'b1; ci = h; end
      default: pe = 1'b0;
    endcase
    return {sr, po, pe, ci};
  endfunction

  // driver: apply inputs just after a rising edge, push expectation, advance model
  task automatic cyc(input string tag, input logic [2:0] cm, input logic [1:0] sm,
                     input logic co, input logic ce, input logic pi, input logic si);
    @(posedge tck);
    #1;
    conn_mode = cm; samp_mode = sm; core_out = co; core_en = ce; pad_in = pi; scan_in = si;
    q_tag.push_back(tag);
    q_exp.push_back({model(cm, sr_a, hold, co, ce, pi), model(cm, sr_b, hold, co, ce, pi)});
    if (sm == 2'd2) hold = sr_a;
    if (sm == 2'd1) begin sr_a = pi; sr_b = co; end
    else if (sm == 2'd3) begin sr_a = si; sr_b = si; end
  endtask

  // monitor: between rising and falling edge, pop and compare
  initial begin
    forever begin
      @(posedge tck);
      #3;
      if (q_exp.size() > 0) begin
        string      t;
        logic [7:0] e;
        logic [7:0] a;
        t = q_tag.pop_front();
        e = q_exp.pop_front();
        a = {scan_out_a, pad_out_a, pad_en_a, core_in_a, scan_out_b, pad_out_b, pad_en_b, core_in_b};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %b expected %b", t, a, e);
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #1 rst_n = 1'b1;
    cyc("R1 reset state", 3'd3, 2'd0, 1, 1, 1, 1);
    cyc("R2 straight a", 3'd0, 2'd0, 1, 0, 0, 0);
    cyc("R2 straight b", 3'd0, 2'd0, 0, 1, 1, 0);
    cyc("R8 shift one", 3'd0, 2'd3, 0, 0, 0, 1);
    cyc("R8 shift zero", 3'd0, 2'd3, 0, 0, 0, 0);
    cyc("R8 shift one again", 3'd0, 2'd3, 0, 0, 0, 1);
    cyc("R9 update before fall", 3'd2, 2'd2, 0, 0, 0, 0);
    cyc("R4 held to core", 3'd2, 2'd0, 0, 1, 0, 0);
    cyc("R3 held to pad", 3'd1, 2'd0, 0, 0, 0, 0);
    cyc("R5 held to both", 3'd3, 2'd0, 0, 0, 0, 0);
    cyc("R6 pad released", 3'd4, 2'd0, 1, 1, 1, 0);
    cyc("R6 code six", 3'd6, 2'd0, 0, 1, 0, 0);
    cyc("R7 capture differs", 3'd2, 2'd1, 1, 0, 0, 0);
    cyc("R7 captured sources", 3'd2, 2'd0, 0, 0, 1, 1);
    cyc("R10 idle keeps", 3'd2, 2'd0, 1, 1, 1, 1);
    cyc("R10 shift keeps hold", 3'd2, 2'd3, 0, 0, 0, 0);
    cyc("R10 capture keeps hold", 3'd2, 2'd1, 0, 0, 0, 0);
    cyc("R9 update zero", 3'd3, 2'd2, 1, 1, 1, 0);
    cyc("R9 update applied", 3'd3, 2'd0, 1, 1, 1, 0);
    cyc("R10 update keeps stage", 3'd0, 2'd0, 0, 0, 0, 0);
    repeat (3) @(posedge tck);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule